// File: doc/BRIEF.md
# Poll-Triggered Transmit Descriptor Engine

This block moves outgoing frames from memory to a MAC transmit side. Software builds a ring of four-word descriptors, points the engine at the ring base, sets the start-transmit control bit, and then writes the poll-demand register. The engine then walks the ring. For each descriptor it owns, it reads the referenced buffer and presents the bytes on a byte stream with start and end markers. When the segment is finished it writes a status word back into the descriptor, which hands the descriptor back to software. The engine stops at the first descriptor it does not own.

A descriptor at byte address D holds four words: status at D, control at D+4, buffer address at D+8 and link address at D+12. The MAC reports completion or abort of the last segment of a frame through a one-cycle completion input that carries the collision and error details. The engine merges these into the written-back status. Padding, CRC and line timing belong to the MAC and are not part of this block.

Register writes use a two-bit register address:
- address 0 is the ring base;
- address 1 is poll demand (the data is ignored);
- address 2 is control, where bit 13 is the start-transmit bit.

Top module: `txd_engine`

## Requirements
- R1: After reset the engine issues no memory request, holds tx_valid low, and its current-descriptor pointer is byte address 0.
- R2: A write to register address 1 (any data) while the engine is idle and control bit 13 is set starts a fetch of the status word at the current pointer. When bit 13 is clear, such a write has no effect: there is no memory access and no byte is sent.
- R3: A descriptor whose status bit 31 is clear stops the engine. The engine writes nothing to that descriptor, sends no byte, and returns to idle.
- R4: The engine streams exactly control[10:0] bytes (1 to 2047), taken from ascending word addresses starting at the buffer address with bits 1:0 treated as zero. Within each 32-bit word, bits 7:0 are sent first.
- R5: tx_sof is high on the first byte of a descriptor only if its control bit 29 is set. tx_eof is high on its last byte only if control bit 30 is set. Both are low on every other byte.
- R6: While tx_valid is high and tx_ready is low, tx_data, tx_sof and tx_eof hold their values and tx_valid stays high.
- R7: For a descriptor with control bit 30 set, the engine waits for mac_done and then writes the status word with these fields, all other bits zero:
  - bit 31 = 0;
  - bit 15 = mac_abort;
  - bit 9 = mac_late;
  - bit 8 = mac_excess;
  - bits 6:3 = mac_coll;
  - bit 1 = mac_under.
- R8: A descriptor without control bit 30 gets status 0 written back as soon as its bytes are sent, without waiting for the MAC.
- R9: After write-back, the next descriptor address is chosen in this order:
  - the ring base if control bit 25 is set;
  - otherwise the link word if control bit 24 is set;
  - otherwise the current address plus 16.
- R10: A write to register address 0 loads both the ring base and the current-descriptor pointer.
- R11: After write-back, fetching continues while control bit 13 is set. Clearing the bit lets the current descriptor finish, after which the engine goes idle without fetching another descriptor.
- R12: A memory request holds mem_addr, mem_we and mem_wdata stable until mem_ack. Each request causes exactly one access: a single-segment descriptor of n bytes followed by a non-owned one costs 6 + ceil(n/4) accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 ring base, 1 poll demand, 2 control |
| reg_wdata | input | 32 | Register write data |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | ADDR_W | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| tx_valid | output | 1 | Byte valid towards the MAC |
| tx_data | output | 8 | Transmit byte |
| tx_sof | output | 1 | First byte of a frame |
| tx_eof | output | 1 | Last byte of a frame |
| tx_ready | input | 1 | MAC accepts the byte |
| mac_done | input | 1 | One-cycle pulse: the frame has completed or been aborted |
| mac_abort | input | 1 | Frame was aborted |
| mac_coll | input | 4 | Collision count |
| mac_late | input | 1 | Late collision seen |
| mac_excess | input | 1 | Excessive collisions |
| mac_under | input | 1 | Transmit underflow |

## Verification
The assertions rely on the memory side raising mem_ack for one cycle only, and only while a request is outstanding. They also rely on the MAC pulsing mac_done only after the end marker of a frame has been accepted. The bench's memory model serves each request one cycle after it sees it and then drops the acknowledge. Its MAC model raises mac_done a few cycles after an accepted tx_eof. Descriptors are built with byte counts of at least 1, word-aligned buffers, and ring-base writes made only while the engine is quiet. This keeps the pointer load from meeting a write-back.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_STAT,
    ST_RD_CTRL,
    ST_RD_BUF,
    ST_RD_LINK,
    ST_RD_WORD,
    ST_STREAM,
    ST_WAIT_MAC,
    ST_WRBACK
  } txd_state_e;

  // descriptor bit positions (shared with software)
  localparam int OWN_BIT    = 31;
  localparam int LEN_W      = 11;
  localparam int FIRST_BIT  = 29;
  localparam int LAST_BIT   = 30;
  localparam int EOR_BIT    = 25;
  localparam int CHAIN_BIT  = 24;
  localparam int ABORT_BIT  = 15;
  localparam int LATE_BIT   = 9;
  localparam int EXCESS_BIT = 8;
  localparam int COLL_LSB   = 3;
  localparam int UNDER_BIT  = 1;
  localparam int START_BIT  = 13;
  localparam int DESC_BYTES = 16;

  localparam logic [1:0] REG_BASE = 2'd0;
  localparam logic [1:0] REG_POLL = 2'd1;
  localparam logic [1:0] REG_CTRL = 2'd2;

  function automatic logic [7:0] byte_lane(input logic [31:0] w, input logic [1:0] idx);
    return w[{idx, 3'b000} +: 8];
  endfunction

  function automatic logic [31:0] pack_status(input logic abort, input logic late,
                                              input logic excess, input logic [3:0] coll,
                                              input logic under);
    logic [31:0] s;
    s = '0;
    s[ABORT_BIT]             = abort;
    s[LATE_BIT]              = late;
    s[EXCESS_BIT]            = excess;
    s[COLL_LSB +: 4]         = coll;
    s[UNDER_BIT]             = under;
    return s;
  endfunction

endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [ADDR_W-1:0] ring_base,
  output logic              base_load,
  output logic              poll,
  output logic              run
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ring_base <= '0;
      base_load <= 1'b0;
      poll      <= 1'b0;
      run       <= 1'b0;
    end else begin
      base_load <= reg_wr && (reg_addr == REG_BASE);
      poll      <= reg_wr && (reg_addr == REG_POLL);
      if (reg_wr && (reg_addr == REG_BASE)) ring_base <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && (reg_addr == REG_CTRL)) run <= reg_wdata[START_BIT];
    end
  end

endmodule

// File: rtl/txd_ring_ptr.sv
module txd_ring_ptr
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              base_load,
  input  logic              advance,
  input  logic              eor,
  input  logic              chained,
  input  logic [ADDR_W-1:0] link_addr,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [ADDR_W-1:0] nxt_ptr
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DESC_BYTES);

  // end-of-ring takes priority over the link word
  always_comb begin
    if (eor)          nxt_ptr = ring_base;
    else if (chained) nxt_ptr = link_addr;
    else              nxt_ptr = cur_ptr + STEP;
  end

  always_ff @(posedge clk) begin
    if (rst)            cur_ptr <= '0;
    else if (base_load) cur_ptr <= ring_base;
    else if (advance)   cur_ptr <= nxt_ptr;
  end

endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  output logic              tx_sof,
  output logic              tx_eof,
  input  logic              tx_ready,
  input  logic              mac_done,
  input  logic              mac_abort,
  input  logic [3:0]        mac_coll,
  input  logic              mac_late,
  input  logic              mac_excess,
  input  logic              mac_under
);

  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFS_BUF  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] OFS_LINK = ADDR_W'(12);

  logic [ADDR_W-1:0] ring_base, cur_ptr, nxt_ptr, link_q;
  logic              base_load, poll, run, advance;
  logic [ADDR_W-3:0] buf_q;
  logic [LEN_W-1:0]  len_q, sent_q, sent_n, len_m1;
  logic              first_q, last_q, eor_q, chain_q;
  logic [31:0]       word_q, wb_status;
  logic [ADDR_W-1:0] word_addr_n;
  txd_state_e        state;

  txd_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .ring_base(ring_base), .base_load(base_load), .poll(poll), .run(run)
  );

  txd_ring_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .ring_base(ring_base), .base_load(base_load),
    .advance(advance), .eor(eor_q), .chained(chain_q), .link_addr(link_q),
    .cur_ptr(cur_ptr), .nxt_ptr(nxt_ptr)
  );

  assign advance     = (state == ST_WRBACK) && mem_ack;
  assign sent_n      = sent_q + LEN_W'(1);
  assign len_m1      = len_q - LEN_W'(1);
  assign word_addr_n = {buf_q, 2'b00} + ADDR_W'({sent_n[LEN_W-1:2], 2'b00});
  assign wb_status   = pack_status(mac_abort, mac_late, mac_excess, mac_coll, mac_under);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
      tx_sof    <= 1'b0;
      tx_eof    <= 1'b0;
      len_q     <= '0;
      sent_q    <= '0;
      first_q   <= 1'b0;
      last_q    <= 1'b0;
      eor_q     <= 1'b0;
      chain_q   <= 1'b0;
      buf_q     <= '0;
      link_q    <= '0;
      word_q    <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (poll && run) begin
            mem_req  <= 1'b1;
            mem_we   <= 1'b0;
            mem_addr <= cur_ptr;
            state    <= ST_RD_STAT;
          end
        end
        ST_RD_STAT: begin
          if (mem_ack) begin
            if (mem_rdata[OWN_BIT]) begin
              mem_addr <= cur_ptr + OFS_CTRL;
              state    <= ST_RD_CTRL;
            end else begin
              mem_req <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        ST_RD_CTRL: begin
          if (mem_ack) begin
            len_q    <= mem_rdata[LEN_W-1:0];
            first_q  <= mem_rdata[FIRST_BIT];
            last_q   <= mem_rdata[LAST_BIT];
            eor_q    <= mem_rdata[EOR_BIT];
            chain_q  <= mem_rdata[CHAIN_BIT];
            mem_addr <= cur_ptr + OFS_BUF;
            state    <= ST_RD_BUF;
          end
        end
        ST_RD_BUF: begin
          if (mem_ack) begin
            buf_q    <= mem_rdata[ADDR_W-1:2];
            mem_addr <= cur_ptr + OFS_LINK;
            state    <= ST_RD_LINK;
          end
        end
        ST_RD_LINK: begin
          if (mem_ack) begin
            link_q   <= mem_rdata[ADDR_W-1:0];
            sent_q   <= '0;
            mem_addr <= {buf_q, 2'b00};
            state    <= ST_RD_WORD;
          end
        end
        ST_RD_WORD: begin
          if (mem_ack) begin
            word_q   <= mem_rdata;
            mem_req  <= 1'b0;
            tx_valid <= 1'b1;
            tx_data  <= byte_lane(mem_rdata, sent_q[1:0]);
            tx_sof   <= first_q && (sent_q == '0);
            tx_eof   <= last_q && (sent_q == len_m1);
            state    <= ST_STREAM;
          end
        end
        ST_STREAM: begin
          if (tx_ready) begin
            sent_q <= sent_n;
            if (sent_n == len_q) begin
              tx_valid <= 1'b0;
              tx_sof   <= 1'b0;
              tx_eof   <= 1'b0;
              if (last_q) begin
                state <= ST_WAIT_MAC;
              end else begin
                mem_req   <= 1'b1;
                mem_we    <= 1'b1;
                mem_addr  <= cur_ptr;
                mem_wdata <= '0;
                state     <= ST_WRBACK;
              end
            end else if (sent_n[1:0] == 2'b00) begin
              tx_valid <= 1'b0;
              tx_sof   <= 1'b0;
              tx_eof   <= 1'b0;
              mem_req  <= 1'b1;
              mem_addr <= word_addr_n;
              state    <= ST_RD_WORD;
            end else begin
              tx_data <= byte_lane(word_q, sent_n[1:0]);
              tx_sof  <= 1'b0;
              tx_eof  <= last_q && (sent_n == len_m1);
            end
          end
        end
        ST_WAIT_MAC: begin
          if (mac_done) begin
            mem_req   <= 1'b1;
            mem_we    <= 1'b1;
            mem_addr  <= cur_ptr;
            mem_wdata <= wb_status;
            state     <= ST_WRBACK;
          end
        end
        ST_WRBACK: begin
          if (mem_ack) begin
            mem_we    <= 1'b0;
            mem_wdata <= '0;
            if (run) begin
              mem_addr <= nxt_ptr;
              state    <= ST_RD_STAT;
            end else begin
              mem_req <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic              mem_ack,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_sof,
  input logic              tx_eof,
  input logic              tx_ready
);

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!mem_req && !tx_valid));

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_sof) && $stable(tx_eof)));

  assert_wb_release_R7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |-> !mem_wdata[31]);

  assert_no_fetch_while_stream_R4: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && tx_valid));

  assert_marker_valid_R5: assert property (@(posedge clk) disable iff (rst)
    (tx_sof || tx_eof) |-> tx_valid);

endmodule

bind txd_engine txd_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ack(mem_ack), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready)
);

// File: tb/txd_engine_tb.sv
module txd_engine_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW         = 32;
  localparam int MEM_WORDS  = 1024;
  localparam int WD_LIMIT   = 150000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [31:0]   mem_rdata = '0;
  logic          tx_valid, tx_sof, tx_eof;
  logic [7:0]    tx_data;
  logic          tx_ready = 1'b1;
  logic          mac_done = 1'b0;
  logic          mac_abort = 1'b0, mac_late = 1'b0, mac_excess = 1'b0, mac_under = 1'b0;
  logic [3:0]    mac_coll = '0;

  logic [31:0]   mem [0:MEM_WORDS-1];
  logic          tb_wr = 1'b0;
  logic [AW-1:0] tb_waddr = '0;
  logic [31:0]   tb_wdata = '0;
  int            acc_cnt = 0;
  int            cyc = 0;
  int            mac_cnt = 0;
  bit            stall_en = 1'b0;
  int            n_checks = 0, n_fail = 0;

  logic [7:0] got_data[$], exp_data[$];
  bit         got_sof[$], got_eof[$], exp_sof[$], exp_eof[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_engine #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_sof(tx_sof), .tx_eof(tx_eof), .tx_ready(tx_ready), .mac_done(mac_done),
    .mac_abort(mac_abort), .mac_coll(mac_coll), .mac_late(mac_late),
    .mac_excess(mac_excess), .mac_under(mac_under)
  );

  // memory model: one access per request, acknowledged one cycle later
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEM_WORDS; i++) mem[i] <= '0;
      mem_ack <= 1'b0;
    end else if (tb_wr) begin
      mem[tb_waddr[11:2]] <= tb_wdata;
    end else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[11:2]];
      if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      acc_cnt   <= acc_cnt + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  // MAC side model: ready pattern, byte capture, completion pulse
  always @(negedge clk) begin
    cyc = cyc + 1;
    mac_done = 1'b0;
    if (mac_cnt != 0) begin
      mac_cnt = mac_cnt - 1;
      if (mac_cnt == 0) mac_done = 1'b1;
    end
    tx_ready = stall_en ? ($urandom_range(0, 3) != 0) : 1'b1;
    if (tx_valid && tx_ready) begin
      got_data.push_back(tx_data);
      got_sof.push_back(tx_sof);
      got_eof.push_back(tx_eof);
      if (tx_eof) mac_cnt = 3;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    wait (cyc >= WD_LIMIT);
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WD_LIMIT);
    summary();
    $finish;
  end

  task automatic chk_eq(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [AW-1:0] a);
    return mem[a[11:2]];
  endfunction

  function automatic logic [31:0] exp_status(input bit ab, input bit lt, input bit ex,
                                             input logic [3:0] co, input bit un);
    return (32'(ab) << 15) | (32'(lt) << 9) | (32'(ex) << 8) | (32'(co) << 3) | (32'(un) << 1);
  endfunction

  task automatic put_word(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_wr = 1'b1; tb_waddr = a; tb_wdata = d;
    @(negedge clk);
    tb_wr = 1'b0;
  endtask

  task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_quiet();
    int q = 0;
    while (q < 12) begin
      @(negedge clk);
      if (!mem_req && !tx_valid && mac_cnt == 0 && !mac_done) q++;
      else q = 0;
    end
  endtask

  task automatic set_mac(input bit ab, input bit lt, input bit ex, input logic [3:0] co, input bit un);
    mac_abort = ab; mac_late = lt; mac_excess = ex; mac_coll = co; mac_under = un;
  endtask

  // writes buffer bytes and descriptor, records expected stream
  task automatic add_desc(input logic [AW-1:0] d, input logic [AW-1:0] b, input int len,
                          input bit fs, input bit ls, input bit eor, input bit ch,
                          input logic [AW-1:0] link);
    logic [31:0] w;
    for (int i = 0; i < (len + 3) / 4; i++) begin
      w = '0;
      for (int k = 0; k < 4; k++) begin
        logic [7:0] by;
        by = 8'($urandom_range(0, 255));
        w[8*k +: 8] = by;
        if (4*i + k < len) begin
          exp_data.push_back(by);
          exp_sof.push_back(fs && (4*i + k == 0));
          exp_eof.push_back(ls && (4*i + k == len - 1));
        end
      end
      put_word(b + AW'(4*i), w);
    end
    put_word(d + 4,  (32'(ls) << 30) | (32'(fs) << 29) | (32'(eor) << 25) | (32'(ch) << 24) | 32'(len));
    put_word(d + 8,  b);
    put_word(d + 12, link);
    put_word(d,      32'h8000_0000);
  endtask

  task automatic check_stream(input string req);
    int bd = 0;
    int bf = 0;
    chk_eq(req, "byte count", got_data.size(), exp_data.size());
    for (int i = 0; i < exp_data.size() && i < got_data.size(); i++) begin
      if (got_data[i] !== exp_data[i]) bd++;
      if (got_sof[i] !== exp_sof[i] || got_eof[i] !== exp_eof[i]) bf++;
    end
    chk_eq(req, "data mismatches", bd, 0);
    chk_eq("R5", "marker mismatches", bf, 0);
    got_data.delete(); got_sof.delete(); got_eof.delete();
    exp_data.delete(); exp_sof.delete(); exp_eof.delete();
  endtask

  initial begin
    int a0;
    logic [31:0] st;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // reset state
    chk_eq("R1", "mem_req after reset", mem_req, 0);
    chk_eq("R1", "tx_valid after reset", tx_valid, 0);

    // descriptor at address 0 with start bit clear: poll ignored
    add_desc(32'h0, 32'h800, 3, 1, 1, 0, 0, 32'h0);
    put_word(32'h10, 32'h1234_5678);
    a0 = acc_cnt;
    reg_write(2'd1, 32'hFFFF_FFFF);
    repeat (30) @(negedge clk);
    chk_eq("R2", "accesses with start clear", acc_cnt - a0, 0);
    chk_eq("R2", "bytes with start clear", got_data.size(), 0);
    chk_eq("R2", "status untouched", rd(32'h0), 32'h8000_0000);

    // start bit set, poll: pointer after reset is address 0
    set_mac(0, 0, 0, 4'd5, 1);
    reg_write(2'd2, 32'h0000_2000);
    a0 = acc_cnt;
    reg_write(2'd1, 32'h0);
    wait_quiet();
    check_stream("R1");
    chk_eq("R7", "written status", rd(32'h0), exp_status(0, 0, 0, 4'd5, 1));
    chk_eq("R3", "non-owned descriptor untouched", rd(32'h10), 32'h1234_5678);
    chk_eq("R12", "access count", acc_cnt - a0, 7);

    // base write moves pointer; two-segment frame, aborted
    add_desc(32'h100, 32'h800, 13, 1, 0, 0, 0, 32'h0);
    add_desc(32'h110, 32'h900, 22, 0, 1, 0, 0, 32'h0);
    put_word(32'h120, 32'h0);
    set_mac(1, 1, 1, 4'd15, 0);
    reg_write(2'd0, 32'h100);
    reg_write(2'd1, 32'h0);
    wait_quiet();
    check_stream("R10");
    chk_eq("R8", "non-last segment status", rd(32'h100), 32'h0);
    chk_eq("R7", "aborted frame status", rd(32'h110), exp_status(1, 1, 1, 4'd15, 0));

    // end-of-ring: 0x120 wraps back to base 0x100
    add_desc(32'h120, 32'hA00, 9, 1, 1, 1, 0, 32'h0);
    add_desc(32'h100, 32'h800, 6, 1, 1, 0, 0, 32'h0);
    put_word(32'h110, 32'h0);
    set_mac(0, 0, 0, 4'd2, 0);
    reg_write(2'd1, 32'h0);
    wait_quiet();
    check_stream("R9");
    chk_eq("R9", "wrapped descriptor written", rd(32'h100), exp_status(0, 0, 0, 4'd2, 0));

    // chained: 0x110 links to 0x180, 0x120 must be skipped
    add_desc(32'h110, 32'h800, 5, 1, 1, 0, 1, 32'h180);
    add_desc(32'h180, 32'h900, 11, 1, 1, 0, 0, 32'h0);
    put_word(32'h190, 32'h0);
    st = exp_data.size();
    for (int i = 0; i < 3; i++) void'(exp_data.pop_back());
    exp_data.delete(); exp_sof.delete(); exp_eof.delete();
    add_desc(32'h110, 32'h800, 5, 1, 1, 0, 1, 32'h180);
    add_desc(32'h180, 32'h900, 11, 1, 1, 0, 0, 32'h0);
    put_word(32'h120, 32'h8000_0000);
    reg_write(2'd1, 32'h0);
    wait_quiet();
    check_stream("R9");
    chk_eq("R9", "skipped sequential descriptor", rd(32'h120), 32'h8000_0000);
    chk_eq("R9", "linked descriptor written", rd(32'h180), exp_status(0, 0, 0, 4'd2, 0));

    // end-of-ring beats chained; base descriptor not owned
    add_desc(32'h190, 32'hA00, 4, 1, 1, 1, 1, 32'h1C0);
    put_word(32'h1C0, 32'h8000_0000);
    put_word(32'h100, 32'h0000_0055);
    reg_write(2'd1, 32'h0);
    wait_quiet();
    check_stream("R9");
    chk_eq("R9", "link ignored when ring ends", rd(32'h1C0), 32'h8000_0000);
    chk_eq("R3", "non-owned base unchanged", rd(32'h100), 32'h0000_0055);

    // clearing start mid-frame: current finishes, next is not fetched
    add_desc(32'h100, 32'h800, 60, 1, 1, 0, 0, 32'h0);
    put_word(32'h110, 32'h8000_0000);
    reg_write(2'd1, 32'h0);
    while (got_data.size() == 0) @(negedge clk);
    reg_write(2'd2, 32'h0);
    wait_quiet();
    check_stream("R11");
    chk_eq("R11", "current descriptor completed", rd(32'h100), exp_status(0, 0, 0, 4'd2, 0));
    chk_eq("R11", "next descriptor still owned", rd(32'h110), 32'h8000_0000);

    // random rings with back-pressure
    reg_write(2'd2, 32'h0000_2000);
    stall_en = 1'b1;
    for (int it = 0; it < 8; it++) begin
      int k;
      bit ab, lt, ex, un;
      logic [3:0] co;
      bit eor;
      k = $urandom_range(1, 3);
      eor = $urandom_range(0, 1);
      ab = $urandom_range(0, 1); lt = $urandom_range(0, 1);
      ex = $urandom_range(0, 1); un = $urandom_range(0, 1);
      co = 4'($urandom_range(0, 15));
      set_mac(ab, lt, ex, co, un);
      for (int j = 0; j < k; j++) begin
        bit ch;
        ch = $urandom_range(0, 1);
        add_desc(AW'(32'h200 + 16*j), AW'(32'h800 + 256*j), $urandom_range(1, 200),
                 j == 0, j == k - 1, eor && (j == k - 1), ch, AW'(32'h200 + 16*(j+1)));
      end
      put_word(AW'(32'h200 + 16*k), 32'h0);
      reg_write(2'd0, 32'h200);
      reg_write(2'd1, 32'h0);
      wait_quiet();
      check_stream("R6");
      for (int j = 0; j < k - 1; j++)
        chk_eq("R8", "random middle status", rd(AW'(32'h200 + 16*j)), 32'h0);
      chk_eq("R7", "random last status", rd(AW'(32'h200 + 16*(k-1))), exp_status(ab, lt, ex, co, un));
    end

    summary();
    $finish;
  end

endmodule